// File: doc/BRIEF.md
# Binary Calendar Counter

This block keeps wall-clock time and date as plain binary fields: seconds, minutes, hours, day of month, month and a year held as an 8-bit offset from 1900. It moves forward one second on every clock cycle where the one-second tick enable is high. Each field carries into the next one. The day field uses a per-month length table with a leap February.

The leap rule is simplified but exact for the 256 years the year field can hold (1900 through 2155). A year gets 29 February days when its offset is a multiple of four, except offsets 0 (1900) and 200 (2100). A load strobe writes every field in a single cycle, which is how software sets the clock. Loaded values are stored as given and are not checked. The next carry out of an out-of-range field follows the same compare rules as normal counting.

Top module: `cal_counter`

## Requirements
- R1: On a tick, seconds step by one while the result stays below 60. When seconds+1 reaches 60 or more, seconds become 0 and minutes are stepped by the same rule (wrap when minutes+1 reaches 60 or more).
- R2: A minute carry steps hours. When hours+1 reaches 24 or more, hours become 0 and the day is stepped. On every day step, hour, minute and second all read 0.
- R3: A stepped day that stays at or below the month length is kept. A stepped day above the month length sets the day to 1 and steps the month. The lengths for months 1 to 12 are 31, 28 (29 in leap years), 31, 30, 31, 30, 31, 31, 30, 31, 30, 31.
- R4: February has 29 days only when year[1:0] is 0 and the year offset is neither 0 nor 200. Otherwise it has 28.
- R5: When month+1 exceeds 12, the month becomes 1 and the year offset is stepped.
- R6: The 8-bit year offset steps from 255 to 0.
- R7: When load is high, all six fields take the load inputs at that clock edge, and the tick is ignored in that cycle.
- R8: With tick and load both low, no field changes.
- R9: Out-of-range loaded values are kept and not corrected. A month value outside 1 to 12 has a length of 31. Carries from such values use the compares of R1, R2, R3 and R5 (for example, second 62 wraps to 0 on the next tick).
- R10: A synchronous active-high reset sets year 0, month 1, day 1 and time 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable |
| load | input | 1 | Load strobe for all fields |
| ld_year | input | 8 | Year offset to load |
| ld_month | input | 4 | Month to load |
| ld_day | input | 5 | Day to load |
| ld_hour | input | 5 | Hour to load |
| ld_min | input | 6 | Minute to load |
| ld_sec | input | 6 | Second to load |
| year | output | 8 | Year offset from 1900 |
| month | output | 4 | Month, 1 to 12 |
| day | output | 5 | Day of month, from 1 |
| hour | output | 5 | Hour, 0 to 23 |
| minute | output | 6 | Minute, 0 to 59 |
| second | output | 6 | Second, 0 to 59 |

## Verification
Local rules are checked by assertions on every cycle. These cover the seconds step and wrap, holding when idle, load priority, the zeroed time after a day step, the leap exception at offset 0 and the year wrap. Properties cannot show whether every month, in every one of the 256 years, gets the right length. Only the bench's sweeps do that. The bench rolls the last day of each month for leap and common years and steps Feb 28 across all year offsets. The effect of out-of-range loads on the next carry is also shown only by the bench's directed scenarios.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int YEAR_W = 8;
  localparam int MON_W  = 4;
  localparam int DAY_W  = 5;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  second;
  } cal_time_t;
endpackage

// File: rtl/cal_field_step.sv
// One counter field: steps when enabled, wraps to WRAP_VAL once value+1 >= lim.
module cal_field_step #(
  parameter int W        = 6,
  parameter int WRAP_VAL = 0
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  logic [W:0]   lim,
  output logic [W-1:0] nxt,
  output logic         carry
);
  logic [W:0] bumped;

  always_comb begin
    bumped = {1'b0, cur} + {{W{1'b0}}, 1'b1};
    nxt    = cur;
    carry  = 1'b0;
    if (en) begin
      if (bumped >= lim) begin
        nxt   = W'(WRAP_VAL);
        carry = 1'b1;
      end else begin
        nxt = bumped[W-1:0];
      end
    end
  end
endmodule

// File: rtl/cal_month_len.sv
// Days in a month; February gets 29 on offsets divisible by 4 except two century years.
module cal_month_len #(
  parameter int MON_W   = 4,
  parameter int DAY_W   = 5,
  parameter int YEAR_W  = 8,
  parameter int NOLEAP0 = 0,
  parameter int NOLEAP1 = 200
) (
  input  logic [MON_W-1:0]  month,
  input  logic [YEAR_W-1:0] year,
  output logic [DAY_W-1:0]  len
);
  logic leap;

  always_comb begin
    leap = (year[1:0] == 2'd0) && (year != YEAR_W'(NOLEAP0)) && (year != YEAR_W'(NOLEAP1));
    case (month)
      MON_W'(2):  len = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4),
      MON_W'(6),
      MON_W'(9),
      MON_W'(11): len = DAY_W'(30);
      default:    len = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int SEC_LIM  = 60,
  parameter int MIN_LIM  = 60,
  parameter int HOUR_LIM = 24,
  parameter int MON_LIM  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [YEAR_W-1:0] ld_year,
  input  logic [MON_W-1:0]  ld_month,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [SEC_W-1:0]  ld_sec,
  output logic [YEAR_W-1:0] year,
  output logic [MON_W-1:0]  month,
  output logic [DAY_W-1:0]  day,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  minute,
  output logic [SEC_W-1:0]  second
);
  localparam int SEC_TOP  = SEC_LIM - 1;
  localparam int MIN_TOP  = MIN_LIM - 1;
  localparam int HOUR_TOP = HOUR_LIM - 1;

  cal_time_t cur_q, nxt_t;
  logic sec_c, min_c, hour_c, day_c, mon_c;
  logic [DAY_W-1:0] mlen;

  cal_field_step #(.W(SEC_W), .WRAP_VAL(0)) u_sec (
    .cur(cur_q.second), .en(tick), .lim((SEC_W+1)'(SEC_LIM)),
    .nxt(nxt_t.second), .carry(sec_c));

  cal_field_step #(.W(MIN_W), .WRAP_VAL(0)) u_min (
    .cur(cur_q.minute), .en(sec_c), .lim((MIN_W+1)'(MIN_LIM)),
    .nxt(nxt_t.minute), .carry(min_c));

  cal_field_step #(.W(HOUR_W), .WRAP_VAL(0)) u_hour (
    .cur(cur_q.hour), .en(min_c), .lim((HOUR_W+1)'(HOUR_LIM)),
    .nxt(nxt_t.hour), .carry(hour_c));

  cal_month_len #(.MON_W(MON_W), .DAY_W(DAY_W), .YEAR_W(YEAR_W)) u_len (
    .month(cur_q.month), .year(cur_q.year), .len(mlen));

  cal_field_step #(.W(DAY_W), .WRAP_VAL(1)) u_day (
    .cur(cur_q.day), .en(hour_c), .lim({1'b0, mlen} + (DAY_W+1)'(1)),
    .nxt(nxt_t.day), .carry(day_c));

  cal_field_step #(.W(MON_W), .WRAP_VAL(1)) u_mon (
    .cur(cur_q.month), .en(day_c), .lim((MON_W+1)'(MON_LIM + 1)),
    .nxt(nxt_t.month), .carry(mon_c));

  always_comb nxt_t.year = mon_c ? cur_q.year + YEAR_W'(1) : cur_q.year;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '{year: '0, month: MON_W'(1), day: DAY_W'(1), hour: '0, minute: '0, second: '0};
    end else if (load) begin
      cur_q <= '{year: ld_year, month: ld_month, day: ld_day, hour: ld_hour,
                 minute: ld_min, second: ld_sec};
    end else if (tick) begin
      cur_q <= nxt_t;
    end
  end

  assign year   = cur_q.year;
  assign month  = cur_q.month;
  assign day    = cur_q.day;
  assign hour   = cur_q.hour;
  assign minute = cur_q.minute;
  assign second = cur_q.second;

  logic eod;
  assign eod = (second == SEC_W'(SEC_TOP)) && (minute == MIN_W'(MIN_TOP)) &&
               (hour == HOUR_W'(HOUR_TOP));

  a_r1_sec_inc: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && second < SEC_W'(SEC_TOP)) |=> (second == $past(second) + SEC_W'(1)));

  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && second == SEC_W'(SEC_TOP)) |=> (second == '0) && (minute != $past(minute)));

  a_r2_day_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && eod) |=> (hour == '0) && (minute == '0) && (second == '0));

  a_r4_no_leap_base: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && eod && month == MON_W'(2) && day == DAY_W'(28) && year == '0)
    |=> (month == MON_W'(3)) && (day == DAY_W'(1)));

  a_r6_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && eod && month == MON_W'(12) && day == DAY_W'(31) && year == '1)
    |=> (year == '0) && (month == MON_W'(1)) && (day == DAY_W'(1)));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (year == $past(ld_year)) && (month == $past(ld_month)) && (day == $past(ld_day)) &&
             (hour == $past(ld_hour)) && (minute == $past(ld_min)) && (second == $past(ld_sec)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(year) && $stable(month) && $stable(day) &&
                         $stable(hour) && $stable(minute) && $stable(second));
endmodule

// File: tb/cal_counter_bench.sv
module cal_counter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, load = 1'b0;
  logic [7:0] ld_year = '0;
  logic [3:0] ld_month = '0;
  logic [4:0] ld_day = '0, ld_hour = '0;
  logic [5:0] ld_min = '0, ld_sec = '0;
  logic [7:0] year;
  logic [3:0] month;
  logic [4:0] day, hour;
  logic [5:0] minute, second;

  int total = 0, bad = 0;
  bit done = 0;
  int my = 0, mmo = 1, md = 1, mh = 0, mmi = 0, ms = 0;

  always #10 clk = ~clk;

  cal_counter u_cal_counter (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .ld_year(ld_year), .ld_month(ld_month), .ld_day(ld_day), .ld_hour(ld_hour),
    .ld_min(ld_min), .ld_sec(ld_sec),
    .year(year), .month(month), .day(day), .hour(hour), .minute(minute), .second(second));

  function automatic int days_in(int mo, int y);
    if (mo == 2) return ((y % 4 == 0) && y != 0 && y != 200) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    ms++;
    if (ms >= 60) begin
      ms = 0; mmi++;
      if (mmi >= 60) begin
        mmi = 0; mh++;
        if (mh >= 24) begin
          mh = 0; md++;
          if (md > days_in(mmo, my)) begin
            md = 1; mmo++;
            if (mmo >= 13) begin
              mmo = 1; my = (my + 1) % 256;
            end
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    total++;
    if (year !== 8'(my) || month !== 4'(mmo) || day !== 5'(md) || hour !== 5'(mh) ||
        minute !== 6'(mmi) || second !== 6'(ms)) begin
      bad++;
      $display("FAIL %s: got %0d/%0d/%0d %0d:%0d:%0d expected %0d/%0d/%0d %0d:%0d:%0d",
               tag, year, month, day, hour, minute, second, my, mmo, md, mh, mmi, ms);
    end
  endtask

  // one clock per call: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit tk, input bit ld, input int y, input int mo, input int d,
                      input int h, input int mi, input int s, input string tag);
    tick = tk; load = ld;
    ld_year = 8'(y); ld_month = 4'(mo); ld_day = 5'(d);
    ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s);
    @(posedge clk);
    if (ld) begin
      my = y & 255; mmo = mo & 15; md = d & 31; mh = h & 31; mmi = mi & 63; ms = s & 63;
    end else if (tk) model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic tk(input string tag);
    step(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic set(input int y, input int mo, input int d, input int h, input int mi,
                     input int s, input string tag);
    step(0, 1, y, mo, d, h, mi, s, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R10 reset state");
    // R1 basic counting and R8 idle gaps
    for (int i = 0; i < 4000; i++) begin
      if (i % 7 == 3) step(0, 0, 9, 9, 9, 9, 9, 9, "R8 idle hold");
      else tk("R1 R2 counting");
    end
    // R2 day rollover with time reset
    set(50, 1, 30, 23, 59, 58, "R7 load");
    tk("R1 second step");
    tk("R2 day rollover zeroes time");
    // R3 month lengths, leap and common years
    for (int mo = 1; mo <= 12; mo++) begin
      set(4, mo, days_in(mo, 4), 23, 59, 59, "R7 load");
      tk("R3 month end leap year");
      set(3, mo, days_in(mo, 3), 23, 59, 59, "R7 load");
      tk("R3 month end common year");
    end
    // R4 Feb 28 across every year offset
    for (int y = 0; y < 256; y++) begin
      set(y, 2, 28, 23, 59, 59, "R7 load");
      tk("R4 february leap rule");
      if (md == 29) begin
        for (int k = 0; k < 86400; k += 3600) step(1, 1, y, 2, 29, 23, 59, 59, "R7 load over tick");
        tk("R4 leap day rolls to march");
      end
    end
    // R5 and R6 year boundaries
    set(99, 12, 31, 23, 59, 59, "R7 load");
    tk("R5 december to january");
    set(255, 12, 31, 23, 59, 59, "R7 load");
    tk("R6 year wraps to zero");
    // R7 load together with tick
    step(1, 1, 17, 6, 15, 12, 30, 59, "R7 load beats tick");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle after load");
    // R9 out-of-range values
    set(10, 3, 5, 7, 8, 62, "R7 load");
    tk("R9 second 62 wraps");
    set(10, 3, 5, 7, 63, 59, "R7 load");
    tk("R9 minute 63 wraps");
    set(10, 3, 5, 30, 59, 59, "R7 load");
    tk("R9 hour 30 wraps");
    set(10, 4, 31, 23, 59, 59, "R7 load");
    tk("R9 april 31 rolls");
    set(10, 14, 31, 23, 59, 59, "R7 load");
    tk("R9 month 14 rolls to year");
    set(10, 0, 30, 23, 59, 59, "R7 load");
    tk("R9 month 0 length 31");
    tk("R9 month 0 continues");
    set(7, 2, 29, 23, 59, 59, "R7 load");
    tk("R9 feb 29 in common year rolls");
    rst = 1'b1;
    @(posedge clk);
    my = 0; mmo = 1; md = 1; mh = 0; mmi = 0; ms = 0;
    @(negedge clk);
    rst = 1'b0;
    compare("R10 reset after run");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule